// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank

This block holds the configuration registers of a display controller that has two overlay windows. Software writes land in a shadow copy of every register. The active copy drives scanout, and it loads from the shadow only at a frame boundary, which a one-cycle vsync pulse marks. As a result, a set of related fields never goes live halfway through a frame.

Software arms a transfer by writing the update request. Each window also has its own protect bit. While that bit is set, the window's shadow fields are held back at vsync, so a window that is only partly programmed stays out of the active set. The request for that window stays pending until the protect bit is released, and the held values then move at the next vsync without a new request.

The global control register has two run bits. The immediate bit drives its output directly. Its frame-synchronous twin goes live only at vsync, which is the moment display DMA starts. Reads always return the shadow contents. The update register and a status output report which transfers are still pending. Writing the soft-reset bit clears the whole bank in one cycle.

Top module: `fsb_bank`

## Requirements
- R1: After reset (rst_n low at a clock edge), every active output, every pending flag, the protect bits and every readable register are zero.
- R2: A write to a window register (address 8 + 4*window + index, with index 0 = control {format[3:1], enable[0]}, 1 = base, 2 = position, 3 = size) is visible on rd_data the cycle after the write edge. It leaves the active outputs unchanged.
- R3: A vsync pulse with no update request pending copies nothing to the active outputs.
- R4: Writing 1 to bit 0 of the update register (address 1) sets every pending flag, which appear on pend_o as {window1, window0, global}. The next vsync loads every unprotected window and the global twin from the shadow, and clears their flags.
- R5: When a window enable bit is cleared in the shadow, the window stays enabled on the outputs until the vsync that transfers it.
- R6: While a window's protect bit (address 2, bit w) is set, vsync leaves that window's active outputs unchanged and keeps its pending flag set. Other windows and the global fields still transfer.
- R7: After a protect bit is cleared, the window's held values transfer at the next vsync without a new update request.
- R8: Global control (address 0): bit 0, run-now, drives run_imm_o the cycle after its write. Bit 1, the frame-synchronous run twin, reaches run_frm_o only at a transferring vsync.
- R9: Writing 1 to bit 7 of global control clears all shadow and active registers, the protect bits and every pending flag by the next cycle. The bit reads back as 0.
- R10: An update request written in the same cycle as a vsync pulse does not transfer on that pulse. Its pending flags stay set for the next vsync.
- R11: Writes to unmapped addresses (3 to 7, and 16 and above) change no register, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Shadow contents at rd_addr (combinational) |
| vsync | input | 1 | One-cycle frame-boundary pulse |
| run_imm_o | output | 1 | Immediate run bit |
| run_frm_o | output | 1 | Active frame-synchronous run bit |
| win_en_o | output | NUM_WIN | Active window enables |
| win_fmt_o | output | NUM_WIN*FMT_W | Active window formats, window 0 in the low bits |
| win_base_o | output | NUM_WIN*DATA_W | Active buffer base per window |
| win_pos_o | output | NUM_WIN*DATA_W | Active position per window |
| win_size_o | output | NUM_WIN*DATA_W | Active size per window |
| pend_o | output | NUM_WIN+1 | Pending transfers {windows..., global} |

## Verification
A wrong pending or protect state shows on pend_o one cycle after the vsync or register write that caused it. It shows on the active window buses at the first vsync that should or should not have transferred. A shadow corruption is visible on rd_data in the cycle after the write. It reaches the active outputs only through a later transfer, so every scenario checks both the readback and the active buses on each side of a vsync. The directed scenarios cover the boundary orderings: protect set across a request, protect release, and a request colliding with a vsync.

// File: rtl/fsb_pkg.sv
// Shared constants and types for the frame-boundary shadow register bank.
// Assumes four word registers per window, so the low two bits of a window
// offset select the register inside the window.
package fsb_pkg;
    localparam int WREGS = 4;

    typedef enum logic [1:0] {
        WR_CTRL = 2'd0,
        WR_BASE = 2'd1,
        WR_POS  = 2'd2,
        WR_SIZE = 2'd3
    } wreg_e;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_GCTRL = 3'd1,
        K_UPD   = 3'd2,
        K_PROT  = 3'd3,
        K_WIN   = 3'd4
    } kind_e;

    localparam int A_GCTRL   = 0;
    localparam int A_UPDATE  = 1;
    localparam int A_PROTECT = 2;
    localparam int A_WIN0    = 8;

    localparam int G_RUN_IMM = 0;
    localparam int G_RUN_FRM = 1;
    localparam int G_SWRST   = 7;
endpackage

// File: rtl/fsb_decode.sv
// Address decoder: classifies a word address as global control, update,
// protect, a window register, or unmapped. It gives the window number and
// the register index. Purely combinational; used once for writes and once
// for reads.
module fsb_decode #(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 6,
    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output fsb_pkg::kind_e    kind,
    output logic [WIN_IW-1:0] win,
    output logic [1:0]        ridx
);
    import fsb_pkg::*;

    localparam int SPAN = NUM_WIN * WREGS;

    logic [ADDR_W-1:0] off;
    assign off = addr - ADDR_W'(A_WIN0);

    // Classify the address and split a window offset into window and index.
    always_comb begin
        kind = K_NONE;
        win  = '0;
        ridx = '0;
        if (addr == ADDR_W'(A_GCTRL)) begin
            kind = K_GCTRL;
        end else if (addr == ADDR_W'(A_UPDATE)) begin
            kind = K_UPD;
        end else if (addr == ADDR_W'(A_PROTECT)) begin
            kind = K_PROT;
        end else if (addr >= ADDR_W'(A_WIN0) && off < ADDR_W'(SPAN)) begin
            kind = K_WIN;
            win  = WIN_IW'(off / ADDR_W'(WREGS));
            ridx = off[1:0];
        end
    end
endmodule

// File: rtl/fsb_glob.sv
// Global state: run bits, per-window protect bits, the global pending flag,
// soft-reset and update-request detection. Assumes the write strobes come
// from the decoder and that vsync lasts exactly one cycle.
module fsb_glob #(
    parameter int NUM_WIN = 2,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gctrl_we,
    input  logic               upd_we,
    input  logic               prot_we,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               vsync,
    output logic               clr,
    output logic               arm,
    output logic [NUM_WIN-1:0] prot,
    output logic               run_imm,
    output logic               run_frm_shd,
    output logic               run_frm_act,
    output logic               g_pend
);
    import fsb_pkg::*;

    assign clr = gctrl_we & wr_data[G_SWRST];
    assign arm = upd_we & wr_data[0] & ~clr;

    // Shadow run bits; soft reset wins over the bits written with it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_imm     <= 1'b0;
            run_frm_shd <= 1'b0;
        end else if (gctrl_we) begin
            run_imm     <= wr_data[G_RUN_IMM];
            run_frm_shd <= wr_data[G_RUN_FRM];
        end
    end

    // Protect bits act at once; they gate transfers, not the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prot <= '0;
        end else if (prot_we) begin
            prot <= wr_data[NUM_WIN-1:0];
        end
    end

    // Global pending: a new request outranks the clear from a vsync.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            g_pend <= 1'b0;
        end else if (arm) begin
            g_pend <= 1'b1;
        end else if (vsync) begin
            g_pend <= 1'b0;
        end
    end

    // Active frame-synchronous run bit loads only at a transferring vsync.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_frm_act <= 1'b0;
        end else if (vsync && g_pend) begin
            run_frm_act <= run_frm_shd;
        end
    end

    a_r8_frm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(vsync && g_pend) && !clr) |=> $stable(run_frm_act));
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (prot == '0 && !g_pend && !run_frm_act && !run_imm));
    a_r10_arm_wins: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> g_pend);
endmodule

// File: rtl/fsb_win.sv
// One window's shadow and active register sets and its pending flag. The
// active set copies the shadow at a vsync when the window is pending and not
// protected. Assumes the control register keeps only enable and format bits.
module fsb_win #(
    parameter int DATA_W = 32,
    parameter int FMT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [1:0]        widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              arm,
    input  logic              vsync,
    input  logic              prot,
    input  logic [1:0]        ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              pend,
    output logic              act_en,
    output logic [FMT_W-1:0]  act_fmt,
    output logic [DATA_W-1:0] act_base,
    output logic [DATA_W-1:0] act_pos,
    output logic [DATA_W-1:0] act_size
);
    import fsb_pkg::*;

    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << (FMT_W + 1)) - 1);

    logic [DATA_W-1:0] shd [WREGS];
    logic [DATA_W-1:0] act [WREGS];
    logic              xfer;

    assign xfer = vsync & pend & ~prot;

    // Shadow write; the control register drops bits it does not define.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < WREGS; i++) shd[i] <= '0;
        end else if (we) begin
            shd[widx] <= (widx == WR_CTRL) ? (wdata & CTRL_MASK) : wdata;
        end
    end

    // Active copy loads the whole window at once on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < WREGS; i++) act[i] <= '0;
        end else if (xfer) begin
            for (int i = 0; i < WREGS; i++) act[i] <= shd[i];
        end
    end

    // Pending flag: set by a request, kept while protected, cleared on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend <= 1'b0;
        end else if (arm) begin
            pend <= 1'b1;
        end else if (xfer) begin
            pend <= 1'b0;
        end
    end

    assign rdata    = shd[ridx];
    assign act_en   = act[WR_CTRL][0];
    assign act_fmt  = act[WR_CTRL][FMT_W:1];
    assign act_base = act[WR_BASE];
    assign act_pos  = act[WR_POS];
    assign act_size = act[WR_SIZE];

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(vsync && pend && !prot) && !clr) |=> ($stable(act_base) && $stable(act_en) && $stable(act_size)));
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && pend && !prot && !clr) |=> (act_base == $past(shd[WR_BASE]) && act_pos == $past(shd[WR_POS])));
    a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && prot && !clr) |=> pend);
endmodule

// File: rtl/fsb_bank.sv
// Top of the frame-boundary shadow register bank. It decodes the register
// port, instantiates the global block and one window block per window, and
// muxes shadow contents onto the read port. Assumes vsync is a single-cycle
// pulse synchronous to clk.
module fsb_bank #(
    parameter int NUM_WIN = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int FMT_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       vsync,
    output logic                       run_imm_o,
    output logic                       run_frm_o,
    output logic [NUM_WIN-1:0]         win_en_o,
    output logic [NUM_WIN*FMT_W-1:0]   win_fmt_o,
    output logic [NUM_WIN*DATA_W-1:0]  win_base_o,
    output logic [NUM_WIN*DATA_W-1:0]  win_pos_o,
    output logic [NUM_WIN*DATA_W-1:0]  win_size_o,
    output logic [NUM_WIN:0]           pend_o
);
    import fsb_pkg::*;

    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    kind_e             wkind, rkind;
    logic [WIN_IW-1:0] wwin, rwin;
    logic [1:0]        wridx, rridx;

    logic               clr, arm, run_frm_shd, g_pend;
    logic [NUM_WIN-1:0] prot, win_pend;
    logic [DATA_W-1:0]  win_rdata [NUM_WIN];

    fsb_decode #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_wdec (
        .addr(wr_addr), .kind(wkind), .win(wwin), .ridx(wridx)
    );
    fsb_decode #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_rdec (
        .addr(rd_addr), .kind(rkind), .win(rwin), .ridx(rridx)
    );

    fsb_glob #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_glob (
        .clk(clk), .rst_n(rst_n),
        .gctrl_we(wr_en && wkind == K_GCTRL),
        .upd_we(wr_en && wkind == K_UPD),
        .prot_we(wr_en && wkind == K_PROT),
        .wr_data(wr_data), .vsync(vsync),
        .clr(clr), .arm(arm), .prot(prot),
        .run_imm(run_imm_o), .run_frm_shd(run_frm_shd),
        .run_frm_act(run_frm_o), .g_pend(g_pend)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        fsb_win #(.DATA_W(DATA_W), .FMT_W(FMT_W)) u_win (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .we(wr_en && wkind == K_WIN && wwin == WIN_IW'(g)),
            .widx(wridx), .wdata(wr_data),
            .arm(arm), .vsync(vsync), .prot(prot[g]),
            .ridx(rridx), .rdata(win_rdata[g]),
            .pend(win_pend[g]),
            .act_en(win_en_o[g]),
            .act_fmt(win_fmt_o[g*FMT_W +: FMT_W]),
            .act_base(win_base_o[g*DATA_W +: DATA_W]),
            .act_pos(win_pos_o[g*DATA_W +: DATA_W]),
            .act_size(win_size_o[g*DATA_W +: DATA_W])
        );
    end

    assign pend_o = {win_pend, g_pend};

    // Read mux: shadow contents, pending status, or zero when unmapped.
    always_comb begin
        rd_data = '0;
        case (rkind)
            K_GCTRL: rd_data = DATA_W'({run_frm_shd, run_imm_o});
            K_UPD:   rd_data = DATA_W'(pend_o);
            K_PROT:  rd_data = DATA_W'(prot);
            K_WIN:   rd_data = win_rdata[rwin];
            default: rd_data = '0;
        endcase
    end

    a_r4_arm_all: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> ($countones(pend_o) == NUM_WIN + 1));
    a_r11_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rkind == K_NONE) |-> (rd_data == '0));
endmodule

// File: tb/sim_fsb_bank.sv
// Directed bench for fsb_bank: one task per scenario, each checking itself.
module sim_fsb_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic vsync = 1'b0;
    logic run_imm_o, run_frm_o;
    logic [NW-1:0] win_en_o;
    logic [NW*FW-1:0] win_fmt_o;
    logic [NW*DW-1:0] win_base_o, win_pos_o, win_size_o;
    logic [NW:0] pend_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsb_bank #(.NUM_WIN(NW), .DATA_W(DW), .ADDR_W(AW), .FMT_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .vsync(vsync), .run_imm_o(run_imm_o), .run_frm_o(run_frm_o),
        .win_en_o(win_en_o), .win_fmt_o(win_fmt_o), .win_base_o(win_base_o),
        .win_pos_o(win_pos_o), .win_size_o(win_size_o), .pend_o(pend_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] wa(input int w, input int r);
        return AW'(8 + 4 * w + r);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic vs();
        vsync = 1'b1;
        tick();
        vsync = 1'b0;
    endtask

    function automatic logic [DW-1:0] base_of(input int w);
        return win_base_o[w*DW +: DW];
    endfunction

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R1 win_en", 64'(win_en_o), 0);
        chk("R1 base", 64'(win_base_o), 0);
        chk("R1 pend", 64'(pend_o), 0);
        chk("R1 run", 64'({run_imm_o, run_frm_o}), 0);
        rd(wa(0, 1), d); chk("R1 read shadow", 64'(d), 0);
        rd(AW'(2), d);   chk("R1 read protect", 64'(d), 0);
    endtask

    task automatic t_shadow();
        logic [DW-1:0] d;
        wr(wa(0, 1), 32'h0000_1000);
        wr(wa(0, 0), 32'h0000_00F5);
        rd(wa(0, 1), d); chk("R2 readback base", 64'(d), 64'h1000);
        rd(wa(0, 0), d); chk("R2 readback ctrl masked", 64'(d), 64'h5);
        chk("R2 active untouched", 64'(base_of(0)), 0);
        vs();
        chk("R3 no request no transfer base", 64'(base_of(0)), 0);
        chk("R3 no request no transfer en", 64'(win_en_o), 0);
    endtask

    task automatic t_update();
        logic [DW-1:0] d;
        wr(wa(1, 1), 32'h0000_2000);
        wr(wa(1, 2), 32'h0010_0020);
        wr(wa(1, 0), 32'h0000_000B);
        wr(AW'(1), 32'h1);
        chk("R4 all pending", 64'(pend_o), 64'h7);
        chk("R4 before vsync", 64'(win_en_o), 0);
        vs();
        chk("R4 enables", 64'(win_en_o), 64'h3);
        chk("R4 formats", 64'(win_fmt_o), 64'(6'b101_010));
        chk("R4 base w0", 64'(base_of(0)), 64'h1000);
        chk("R4 base w1", 64'(base_of(1)), 64'h2000);
        chk("R4 pos w1", 64'(win_pos_o[DW +: DW]), 64'h0010_0020);
        chk("R4 pend cleared", 64'(pend_o), 0);
        rd(AW'(1), d); chk("R4 update reads clear", 64'(d), 0);
    endtask

    task automatic t_disable_hold();
        wr(wa(0, 0), 32'h4);
        chk("R5 still enabled after write", 64'(win_en_o), 64'h3);
        wr(AW'(1), 32'h1);
        tick();
        chk("R5 still enabled before vsync", 64'(win_en_o), 64'h3);
        vs();
        chk("R5 disabled at vsync", 64'(win_en_o), 64'h2);
    endtask

    task automatic t_protect();
        wr(AW'(2), 32'h1);
        wr(wa(0, 1), 32'h0000_3000);
        wr(wa(1, 1), 32'h0000_4000);
        wr(AW'(1), 32'h1);
        vs();
        chk("R6 protected window held", 64'(base_of(0)), 64'h1000);
        chk("R6 other window moved", 64'(base_of(1)), 64'h4000);
        chk("R6 pending kept", 64'(pend_o), 64'h2);
        vs();
        chk("R6 still held on later vsync", 64'(base_of(0)), 64'h1000);
    endtask

    task automatic t_unprotect();
        wr(AW'(2), 32'h0);
        chk("R7 no move before vsync", 64'(base_of(0)), 64'h1000);
        vs();
        chk("R7 moves at next vsync", 64'(base_of(0)), 64'h3000);
        chk("R7 pending cleared", 64'(pend_o), 0);
    endtask

    task automatic t_run();
        wr(AW'(0), 32'h3);
        chk("R8 immediate bit live", 64'(run_imm_o), 1);
        chk("R8 twin not live", 64'(run_frm_o), 0);
        vs();
        chk("R8 twin waits for request", 64'(run_frm_o), 0);
        wr(AW'(1), 32'h1);
        chk("R8 twin waits for vsync", 64'(run_frm_o), 0);
        vs();
        chk("R8 twin live", 64'(run_frm_o), 1);
    endtask

    task automatic t_same_cycle();
        wr(wa(1, 3), 32'h77);
        wr_en = 1'b1; wr_addr = AW'(1); wr_data = 32'h1; vsync = 1'b1;
        tick();
        wr_en = 1'b0; vsync = 1'b0;
        chk("R10 no transfer on colliding vsync", 64'(win_size_o[DW +: DW]), 0);
        chk("R10 pending stays set", 64'(pend_o), 64'h7);
        vs();
        chk("R10 transfer on next vsync", 64'(win_size_o[DW +: DW]), 64'h77);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] d;
        wr(AW'(3), 32'hFFFF_FFFF);
        wr(AW'(16), 32'hFFFF_FFFF);
        wr(AW'(63), 32'hFFFF_FFFF);
        rd(AW'(3), d);  chk("R11 read unmapped 3", 64'(d), 0);
        rd(AW'(16), d); chk("R11 read unmapped 16", 64'(d), 0);
        rd(AW'(0), d);  chk("R11 gctrl unchanged", 64'(d), 64'h3);
        rd(AW'(2), d);  chk("R11 protect unchanged", 64'(d), 0);
        rd(wa(1, 3), d); chk("R11 window unchanged", 64'(d), 64'h77);
        chk("R11 no pending", 64'(pend_o), 0);
    endtask

    task automatic t_swrst();
        logic [DW-1:0] d;
        wr(AW'(2), 32'h2);
        wr(AW'(1), 32'h1);
        wr(AW'(0), 32'h83);
        chk("R9 enables cleared", 64'(win_en_o), 0);
        chk("R9 base cleared", 64'(win_base_o), 0);
        chk("R9 pend cleared", 64'(pend_o), 0);
        chk("R9 run cleared", 64'({run_imm_o, run_frm_o}), 0);
        rd(AW'(0), d);   chk("R9 gctrl reads 0", 64'(d), 0);
        rd(AW'(2), d);   chk("R9 protect cleared", 64'(d), 0);
        rd(wa(0, 1), d); chk("R9 shadow cleared", 64'(d), 0);
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_shadow();
        t_update();
        t_disable_hold();
        t_protect();
        t_unprotect();
        t_run();
        t_same_cycle();
        t_unmapped();
        t_swrst();
        finished = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            report();
        end
    end
endmodule